// File: doc/BRIEF.md
# DC-Only Block Reconstruction Adder

This block rebuilds a small picture block when its residual has only a DC coefficient. Every reconstructed pixel then equals its predicted pixel plus one shared constant. The block takes the signed DC coefficient and a shape code. It scales the coefficient in two integer stages whose constants depend on the shape. It then adds the constant to each predicted pixel in the stream and saturates the result to 8 bits.

Predicted pixels enter in raster order, one per cycle while the input valid is high. Each reconstructed pixel leaves one cycle later, and a flag marks the final pixel of each block. The DC value and the shape are sampled on the first pixel of a block. They are held until that block's last pixel has been accepted, so the next block can follow with no idle cycle.

Top module: `dc_recon_adder`

## Requirements
- R1: Shape code 0 (4 wide, 4 tall): s = (17*dc + 4) >> 3, then offset = (17*s + 64) >> 7, all shifts arithmetic on signed values.
- R2: Shape code 1 (4 wide, 8 tall): s = (17*dc + 4) >> 3, then offset = (12*s + 64) >> 7.
- R3: Shape code 2 (8 wide, 4 tall): s = (3*dc + 1) >> 1, then offset = (17*s + 64) >> 7.
- R4: Shape code 3 (8 wide, 8 tall): s = (3*dc + 1) >> 1, then offset = (3*s + 16) >> 5.
- R5: A positive or zero offset is clipped to at most 255 and added with saturation, so the output is never below the input pixel and never above 255.
- R6: A negative offset is negated, clipped to at most 255 and subtracted with saturation, so the output is never above the input pixel and never below 0.
- R7: Each accepted pixel produces exactly one output pixel, with the output valid high on the following cycle and the order kept. Cycles with the input valid low produce no output.
- R8: A block is exactly width x height accepted pixels. The end flag is high together with the output of the last pixel of each block and low otherwise.
- R9: The DC value and shape code are sampled only with the first pixel of a block. Changes to them on later pixels of the same block have no effect on that block's outputs.
- R10: While reset is held, the output valid and the end flag are low. The first pixel accepted after reset starts a new block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dc_i | input | DC_W | Signed DC coefficient, sampled on the first pixel of a block |
| shape_i | input | 2 | Block shape: 0=4x4, 1=4 wide 8 tall, 2=8 wide 4 tall, 3=8x8 |
| pix_valid_i | input | 1 | Predicted pixel valid |
| pix_i | input | PIX_W | Predicted pixel |
| pix_valid_o | output | 1 | Reconstructed pixel valid |
| pix_o | output | PIX_W | Reconstructed pixel |
| blk_end_o | output | 1 | Last pixel of the block |

## Verification
A wrong held offset or shape shows up on the second pixel of a block. It appears one cycle after that pixel is accepted, as a pixel value that differs from the prediction plus the expected constant. A miscounting pixel counter moves the end flag away from pixel width x height. It also makes the following block take the wrong DC value, and both errors appear within that block. Saturation faults show only at the extremes, so the directed cases use pixels near 0 and 255 with large DC values of both signs.

// File: rtl/dcadd_pkg.sv
package dcadd_pkg;
  typedef enum logic [1:0] {
    SHP_4X4 = 2'd0,
    SHP_4X8 = 2'd1,
    SHP_8X4 = 2'd2,
    SHP_8X8 = 2'd3
  } shape_e;

  // bit 1: width is long side, bit 0: height is long side
  function automatic logic wide_f(input logic [1:0] s);
    return s[1];
  endfunction

  function automatic logic tall_f(input logic [1:0] s);
    return s[0];
  endfunction
endpackage

// File: rtl/dcadd_scale.sv
module dcadd_scale #(
  parameter int DC_W  = 16,
  parameter int PIX_W = 8
) (
  input  logic [DC_W-1:0]  dc_i,
  input  logic [1:0]       shape_i,
  output logic [PIX_W-1:0] mag_o,
  output logic             neg_o
);
  import dcadd_pkg::*;

  localparam int INT_W = DC_W + 12;
  localparam logic signed [INT_W-1:0] K1   = 1;
  localparam logic signed [INT_W-1:0] K3   = 3;
  localparam logic signed [INT_W-1:0] K4   = 4;
  localparam logic signed [INT_W-1:0] K12  = 12;
  localparam logic signed [INT_W-1:0] K16  = 16;
  localparam logic signed [INT_W-1:0] K17  = 17;
  localparam logic signed [INT_W-1:0] K64  = 64;
  localparam logic signed [INT_W-1:0] KMAX = (1 <<< PIX_W) - 1;

  logic signed [INT_W-1:0] dcx, s1, s2, amag;

  always_comb begin
    dcx = {{(INT_W-DC_W){dc_i[DC_W-1]}}, dc_i};
    // row stage
    if (wide_f(shape_i)) s1 = (dcx * K3 + K1) >>> 1;
    else                 s1 = (dcx * K17 + K4) >>> 3;
    // column stage
    if (!tall_f(shape_i))     s2 = (s1 * K17 + K64) >>> 7;
    else if (!wide_f(shape_i)) s2 = (s1 * K12 + K64) >>> 7;
    else                       s2 = (s1 * K3 + K16) >>> 5;
    neg_o = s2[INT_W-1];
    amag  = neg_o ? -s2 : s2;
    mag_o = (amag > KMAX) ? {PIX_W{1'b1}} : amag[PIX_W-1:0];
  end
endmodule

// File: rtl/dcadd_sat.sv
module dcadd_sat #(
  parameter int PIX_W = 8
) (
  input  logic [PIX_W-1:0] pix_i,
  input  logic [PIX_W-1:0] mag_i,
  input  logic             neg_i,
  output logic [PIX_W-1:0] pix_o
);
  logic [PIX_W:0] t;

  always_comb begin
    if (neg_i) begin
      t     = {1'b0, pix_i} - {1'b0, mag_i};
      pix_o = t[PIX_W] ? '0 : t[PIX_W-1:0];
    end else begin
      t     = {1'b0, pix_i} + {1'b0, mag_i};
      pix_o = t[PIX_W] ? '1 : t[PIX_W-1:0];
    end
  end
endmodule

// File: rtl/dc_recon_adder.sv
module dc_recon_adder #(
  parameter int PIX_W    = 8,
  parameter int DC_W     = 16,
  parameter int SHORT_SD = 4,
  parameter int LONG_SD  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DC_W-1:0]  dc_i,
  input  logic [1:0]       shape_i,
  input  logic             pix_valid_i,
  input  logic [PIX_W-1:0] pix_i,
  output logic             pix_valid_o,
  output logic [PIX_W-1:0] pix_o,
  output logic             blk_end_o
);
  import dcadd_pkg::*;

  localparam int MAX_PIX = LONG_SD * LONG_SD;
  localparam int CNT_W   = $clog2(MAX_PIX);

  logic [CNT_W-1:0] cnt_q;
  logic [PIX_W-1:0] mag_q, new_mag, cur_mag, sum;
  logic             neg_q, new_neg, cur_neg;
  logic [1:0]       shape_q, cur_shape;
  logic             first, last;
  logic [CNT_W:0]   cur_len;

  dcadd_scale #(.DC_W(DC_W), .PIX_W(PIX_W)) u_scale (
    .dc_i(dc_i), .shape_i(shape_i), .mag_o(new_mag), .neg_o(new_neg)
  );

  assign first     = (cnt_q == '0);
  assign cur_mag   = first ? new_mag : mag_q;
  assign cur_neg   = first ? new_neg : neg_q;
  assign cur_shape = first ? shape_i : shape_q;

  always_comb begin
    unique case (cur_shape)
      SHP_4X4: cur_len = (CNT_W+1)'(SHORT_SD * SHORT_SD);
      SHP_8X8: cur_len = (CNT_W+1)'(LONG_SD * LONG_SD);
      default: cur_len = (CNT_W+1)'(SHORT_SD * LONG_SD);
    endcase
  end

  assign last = ({1'b0, cnt_q} == cur_len - 1'b1);

  dcadd_sat #(.PIX_W(PIX_W)) u_sat (
    .pix_i(pix_i), .mag_i(cur_mag), .neg_i(cur_neg), .pix_o(sum)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      mag_q   <= '0;
      neg_q   <= 1'b0;
      shape_q <= '0;
    end else if (pix_valid_i) begin
      if (first) begin
        mag_q   <= new_mag;
        neg_q   <= new_neg;
        shape_q <= shape_i;
      end
      cnt_q <= last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o <= 1'b0;
      pix_o       <= '0;
      blk_end_o   <= 1'b0;
    end else begin
      pix_valid_o <= pix_valid_i;
      blk_end_o   <= pix_valid_i && last;
      if (pix_valid_i) pix_o <= sum;
    end
  end

  AST_OUT_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o == $past(pix_valid_i)); // R7
  AST_END_WITH_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_end_o |-> pix_valid_o); // R8
  AST_CNT_IN_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < cur_len); // R8
  AST_HOLD_PARAMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q != '0) |=> ($stable(mag_q) && $stable(neg_q) && $stable(shape_q))); // R9
  AST_ADD_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && !cur_neg) |-> (sum >= pix_i)); // R5
  AST_SUB_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_valid_i && cur_neg) |-> (sum <= pix_i)); // R6
endmodule

// File: tb/sim_dc_recon_adder.sv
module sim_dc_recon_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] dc = '0;
  logic [1:0]  shape = '0;
  logic        vin = 1'b0;
  logic [7:0]  pin = '0;
  logic        vout;
  logic [7:0]  pout;
  logic        eout;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dc_recon_adder u0 (
    .clk_i(clk), .rst_ni(rst_n), .dc_i(dc), .shape_i(shape),
    .pix_valid_i(vin), .pix_i(pin),
    .pix_valid_o(vout), .pix_o(pout), .blk_end_o(eout)
  );

  function automatic int exp_off(input int sh, input int d);
    int s1;
    if (sh >= 2) s1 = (3 * d + 1) >>> 1;
    else         s1 = (17 * d + 4) >>> 3;
    case (sh)
      0, 2:    return (17 * s1 + 64) >>> 7;
      1:       return (12 * s1 + 64) >>> 7;
      default: return (3 * s1 + 16) >>> 5;
    endcase
  endfunction

  function automatic int exp_pix(input int p, input int off);
    int r = p + off;
    if (r < 0) r = 0;
    if (r > 255) r = 255;
    return r;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input int p, input int off, input bit is_last);
    chk("R7", vout, 1);
    chk(req, pout, exp_pix(p, off));
    chk("R8", eout, is_last);
  endtask

  // one block; disturb drives other dc/shape after the first pixel
  task automatic run_block(input string req, input int sh, input int d,
                           input int seed, input int step,
                           input bit disturb, input int gap_at);
    int n = ((sh >= 2) ? 8 : 4) * ((sh % 2 == 1) ? 8 : 4);
    int off = exp_off(sh, d);
    int prev_p = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k > 0) chk_out(req, prev_p, off, 1'b0);
      if (k > 0 && k == gap_at) begin
        vin = 1'b0;
        @(negedge clk);
        chk("R7", vout, 0);
      end
      prev_p = (seed + k * step) & 255;
      vin   = 1'b1;
      pin   = 8'(prev_p);
      dc    = (disturb && k > 0) ? 16'(~d) : 16'(d);
      shape = (disturb && k > 0) ? 2'(~sh) : 2'(sh);
    end
    @(negedge clk);
    chk_out(req, prev_p, off, 1'b1);
    vin = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R10", vout, 0);
    chk("R10", eout, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", vout, 0);
  endtask

  task automatic t_shapes;
    run_block("R1", 0, 100, 10, 37, 0, -1);
    run_block("R1", 0, -7, 90, 11, 0, -1);
    run_block("R2", 1, 300, 5, 29, 0, -1);
    run_block("R2", 1, -301, 200, 3, 0, -1);
    run_block("R3", 2, 55, 77, 41, 0, -1);
    run_block("R3", 2, -1, 1, 13, 0, -1);
    run_block("R4", 3, 9, 128, 7, 0, -1);
    run_block("R4", 3, -333, 60, 19, 0, -1);
  endtask

  task automatic t_saturate;
    run_block("R5", 3, 32767, 240, 1, 0, -1);
    run_block("R5", 0, 2000, 200, 5, 0, -1);
    run_block("R6", 3, -32768, 3, 1, 0, -1);
    run_block("R6", 2, -2500, 30, 9, 0, -1);
  endtask

  task automatic t_hold_and_gaps;
    run_block("R9", 1, 777, 50, 23, 1, -1);
    run_block("R9", 2, -900, 150, 17, 1, 5);
    run_block("R8", 0, 1, 0, 1, 0, 15);
    @(negedge clk);
    chk("R7", vout, 0);
    chk("R8", eout, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_shapes();
    t_saturate();
    t_hold_and_gaps();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule